// File: doc/BRIEF.md
# Per-Queue Managed/Free Packet Release Scheduler

This block merges several packet sources onto one output word stream. Source 0 is meant for digitiser sample packets and each further source carries the time stamp packets of one front-end chip. Each source holds only complete packets, so whole packets can be read out one word at a time. It raises `src_pkt_avail` while at least one packet is stored and presents that packet's current word on its slice of `src_data`, together with `src_last`. The block pops words with `src_pop`.

Each source has its own release mode bit. In free mode a stored packet is eligible at once. In managed mode the source is eligible only while it holds a release credit. Each pulse on that source's own `send_trig` adds one credit, and each packet started in managed mode uses one. A trigger that arrives while the source is empty still adds a credit, which a later packet uses. When a source changes from managed to free, its credits are cleared and any packets it holds become eligible straight away. Among the eligible sources a round-robin arbiter picks one, and that source's whole packet is forwarded before any other source is considered.

Top module: `pkt_release_sched`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` is 0 and no `src_pop` bit is set.
- R2: A source in free mode (`free_mode[i]`=1) with a stored packet has that packet forwarded without any trigger.
- R3: A source in managed mode forwards no packet without a credit, and each one-cycle `send_trig[i]` pulse releases exactly one packet, the oldest one held.
- R4: A trigger on one source never releases a packet from another source.
- R5: Triggers received while a managed source is empty are counted, up to 2^CW-1, and each one releases one packet once packets arrive.
- R6: On a change from managed to free, held packets become eligible at once and the credit count is cleared, so switching back to managed leaves the source with no credits.
- R7: When several sources stay eligible, successive packets are granted round-robin, so two sources that are both continuously eligible alternate.
- R8: Every packet is forwarded whole and in order, from its first word to its `last` word, with `out_src` constant and no word from another source in between. Packets from each source leave in the order they were stored.
- R9: While `out_valid`=1 and `out_ready`=0, the block holds `out_valid`, `out_data`, `out_last` and `out_src` stable and pops nothing.
- R10: Triggers received while a source is in free mode add no credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| free_mode | input | NQ | Release mode per source: 1 = free, 0 = managed |
| send_trig | input | NQ | One-cycle release trigger per source |
| src_pkt_avail | input | NQ | Source holds at least one complete packet |
| src_data | input | NQ*W | Current word of each source, source i at bits [i*W +: W] |
| src_last | input | NQ | Current word of each source is the last word of its packet |
| src_pop | output | NQ | Pop the current word from the source |
| out_valid | output | 1 | Output word valid |
| out_data | output | W | Output word |
| out_last | output | 1 | Output word ends a packet |
| out_src | output | IW | Index of the source being forwarded |
| out_ready | input | 1 | Downstream accepts the word |

## Verification
A wrong credit count shows up as a managed source that releases a packet too many or one too few, or as a released packet after a trigger that should have been ignored. This becomes visible at the output within a few cycles of the source becoming eligible. A broken owner register or arbiter pointer shows up on the first word of the next packet as a change of `out_src` in the middle of a packet, a word out of order, or two sources that do not alternate. The bench tags every word with its source, its packet number and its position in the packet, so any of these faults fails a word-level comparison as soon as the word is accepted.

// File: rtl/pkt_sched_pkg.sv
package pkt_sched_pkg;

    typedef enum logic {
        SND_IDLE = 1'b0,
        SND_BUSY = 1'b1
    } snd_state_e;

    // index a+b reduced modulo n, for a,b < n
    function automatic int wrap_add(input int a, input int b, input int n);
        int s;
        s = a + b;
        if (s >= n) s = s - n;
        return s;
    endfunction

endpackage

// File: rtl/sched_credit.sv
module sched_credit #(
    parameter int unsigned CW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic free,
    input  logic take,
    output logic has_credit
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || free) begin
            cnt <= '0;
        end else if (trig && !take) begin
            if (cnt != CMAX) cnt <= cnt + 1'b1;
        end else if (!trig && take) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign has_credit = (cnt != '0);

    // R6: credits are gone one cycle after entering free mode
    p_clear_on_free_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(free) |=> !has_credit);

    // R3: a managed release only happens against a held credit
    p_take_needs_credit_r3: assert property (@(posedge clk) disable iff (rst)
        take |-> has_credit);

    // R10: no credit survives a cycle spent in free mode
    p_free_no_credit_r10: assert property (@(posedge clk) disable iff (rst)
        free |=> !has_credit);

endmodule

// File: rtl/sched_rr_arb.sv
module sched_rr_arb
    import pkt_sched_pkg::*;
#(
    parameter int unsigned NQ = 5,
    localparam int unsigned IW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NQ-1:0] req,
    input  logic          take,
    output logic          gnt_any,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] ptr;

    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int k = 0; k < NQ; k++) begin
            int idx;
            idx = wrap_add(int'(ptr), k, NQ);
            if (!gnt_any && req[idx]) begin
                gnt_any = 1'b1;
                gnt_idx = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr <= '0;
        else if (take && gnt_any) ptr <= IW'(wrap_add(int'(gnt_idx), 1, NQ));
    end

    // R7: the pointer always names a real source
    p_ptr_in_range_r7: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < NQ);

endmodule

// File: rtl/pkt_release_sched.sv
module pkt_release_sched
    import pkt_sched_pkg::*;
#(
    parameter int unsigned NQ = 5,
    parameter int unsigned W  = 16,
    parameter int unsigned CW = 4,
    localparam int unsigned IW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NQ-1:0]   free_mode,
    input  logic [NQ-1:0]   send_trig,
    input  logic [NQ-1:0]   src_pkt_avail,
    input  logic [NQ*W-1:0] src_data,
    input  logic [NQ-1:0]   src_last,
    output logic [NQ-1:0]   src_pop,
    output logic            out_valid,
    output logic [W-1:0]    out_data,
    output logic            out_last,
    output logic [IW-1:0]   out_src,
    input  logic            out_ready
);
    snd_state_e    state;
    logic [IW-1:0] owner;
    logic [NQ-1:0] has_credit;
    logic [NQ-1:0] eligible;
    logic [NQ-1:0] take;
    logic          gnt_any;
    logic [IW-1:0] gnt_idx;
    logic          start;

    assign start = (state == SND_IDLE) && gnt_any;

    for (genvar i = 0; i < NQ; i++) begin : g_q
        assign eligible[i] = src_pkt_avail[i] && (free_mode[i] || has_credit[i]);
        assign take[i]     = start && (int'(gnt_idx) == i) && !free_mode[i];
        assign src_pop[i]  = (state == SND_BUSY) && (int'(owner) == i) && out_ready;

        sched_credit #(.CW(CW)) u_cred (
            .clk        (clk),
            .rst        (rst),
            .trig       (send_trig[i]),
            .free       (free_mode[i]),
            .take       (take[i]),
            .has_credit (has_credit[i])
        );
    end

    sched_rr_arb #(.NQ(NQ)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (eligible),
        .take    (start),
        .gnt_any (gnt_any),
        .gnt_idx (gnt_idx)
    );

    always_comb begin
        out_data = '0;
        out_last = 1'b0;
        for (int i = 0; i < NQ; i++) begin
            if (int'(owner) == i) begin
                out_data = src_data[i*W +: W];
                out_last = src_last[i];
            end
        end
    end

    assign out_valid = (state == SND_BUSY);
    assign out_src   = owner;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SND_IDLE;
            owner <= '0;
        end else if (state == SND_IDLE) begin
            if (gnt_any) begin
                state <= SND_BUSY;
                owner <= gnt_idx;
            end
        end else if (out_ready && out_last) begin
            state <= SND_IDLE;
        end
    end

    // R1: idle during and right after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && src_pop == '0));

    // R8: the owner stays fixed until the last word is taken
    p_no_interleave_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !(out_ready && out_last)) |=> (out_valid && $stable(out_src)));

    // R9: a stalled word is held
    p_hold_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R8: at most one source is popped at a time
    p_single_pop_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_pop));

    // R3: a managed source is only granted while it holds a credit
    p_managed_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !free_mode[gnt_idx]) |-> has_credit[gnt_idx]);

endmodule

// File: tb/tb_pkt_release_sched.sv
module tb_pkt_release_sched;
    localparam int NQ = 5;
    localparam int W  = 16;
    localparam int CW = 4;
    localparam int IW = 3;
    localparam time CLK_PERIOD = 10ns;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NQ-1:0]   free_mode = '0;
    logic [NQ-1:0]   send_trig = '0;
    logic [NQ-1:0]   src_pkt_avail = '0;
    logic [NQ*W-1:0] src_data = '0;
    logic [NQ-1:0]   src_last = '0;
    logic [NQ-1:0]   src_pop;
    logic            out_valid;
    logic [W-1:0]    out_data;
    logic            out_last;
    logic [IW-1:0]   out_src;
    logic            out_ready = 1'b1;

    pkt_release_sched #(.NQ(NQ), .W(W), .CW(CW)) dut (
        .clk(clk), .rst(rst), .free_mode(free_mode), .send_trig(send_trig),
        .src_pkt_avail(src_pkt_avail), .src_data(src_data), .src_last(src_last),
        .src_pop(src_pop), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_src(out_src), .out_ready(out_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // word = {last, src[3:0], pkt[5:0], idx[5:0]}
    logic [16:0] srcq [NQ][$];
    logic [16:0] expq [NQ][$];
    int pkt_no [NQ];
    int rel_cnt [NQ];
    int order [$];
    int n_chk = 0;
    int n_fail = 0;
    int cur_src = 0;
    bit in_pkt = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // driver: store packets at the source and push them to the scoreboard
    task automatic load(input int s, input int npk, input int len);
        for (int p = 0; p < npk; p++) begin
            for (int k = 0; k < len; k++) begin
                logic [16:0] w;
                w = {(k == len-1), 4'(s), 6'(pkt_no[s]), 6'(k)};
                srcq[s].push_back(w);
                expq[s].push_back(w);
            end
            pkt_no[s]++;
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int s);
        send_trig[s] = 1'b1;
        tick(1);
        send_trig[s] = 1'b0;
        tick(1);
    endtask

    // source model
    always @(posedge clk) begin
        for (int i = 0; i < NQ; i++) begin
            if (src_pop[i] && srcq[i].size() > 0) void'(srcq[i].pop_front());
            src_pkt_avail[i] <= (srcq[i].size() > 0);
            src_data[i*W +: W] <= (srcq[i].size() > 0) ? srcq[i][0][15:0] : '0;
            src_last[i] <= (srcq[i].size() > 0) ? srcq[i][0][16] : 1'b0;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            int s;
            s = int'(out_src);
            if (in_pkt) check(s == cur_src, "R8 source change inside packet", s, cur_src);
            if (s >= NQ || expq[s].size() == 0) begin
                check(1'b0, "R8 unexpected word", int'(out_data), -1);
            end else begin
                logic [16:0] e;
                e = expq[s].pop_front();
                check({out_last, out_data} == e, "R8 word", int'({out_last, out_data}), int'(e));
            end
            in_pkt = !out_last;
            cur_src = s;
            if (out_last && s < NQ) begin
                rel_cnt[s]++;
                order.push_back(s);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] held;
        int st;
        for (int i = 0; i < NQ; i++) begin
            pkt_no[i] = 0;
            rel_cnt[i] = 0;
        end
        free_mode = 5'b00001;
        tick(4);
        check(!out_valid, "R1 out_valid in reset", int'(out_valid), 0);
        check(src_pop == '0, "R1 pop in reset", int'(src_pop), 0);
        rst = 1'b0;
        tick(1);
        check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);

        // R2 free source
        load(0, 2, 3);
        tick(40);
        check(rel_cnt[0] == 2, "R2 free release", rel_cnt[0], 2);

        // R3 / R4 managed source
        load(1, 3, 4);
        tick(40);
        check(rel_cnt[1] == 0, "R3 held without trigger", rel_cnt[1], 0);
        pulse(2);
        tick(30);
        check(rel_cnt[1] == 0, "R4 foreign trigger", rel_cnt[1], 0);
        pulse(1);
        tick(30);
        check(rel_cnt[1] == 1, "R3 one per trigger", rel_cnt[1], 1);

        // R5 trigger while empty: source 2 now has two credits
        pulse(2);
        tick(5);
        load(2, 3, 2);
        tick(40);
        check(rel_cnt[2] == 2, "R5 early triggers", rel_cnt[2], 2);

        // R6 managed to free releases held packets
        free_mode[1] = 1'b1;
        tick(40);
        check(rel_cnt[1] == 3, "R6 held become eligible", rel_cnt[1], 3);

        // R6 credits cleared by the switch
        pulse(3); pulse(3); pulse(3);
        free_mode[3] = 1'b1;
        tick(2);
        free_mode[3] = 1'b0;
        tick(2);
        load(3, 1, 2);
        tick(40);
        check(rel_cnt[3] == 0, "R6 credits cleared", rel_cnt[3], 0);

        // R10 triggers in free mode ignored
        free_mode[4] = 1'b1;
        tick(2);
        pulse(4); pulse(4);
        free_mode[4] = 1'b0;
        tick(2);
        load(4, 1, 2);
        tick(40);
        check(rel_cnt[4] == 0, "R10 free triggers ignored", rel_cnt[4], 0);

        // R7 round robin between two continuously eligible sources
        load(3, 2, 3);
        load(4, 2, 3);
        tick(2);
        st = order.size();
        free_mode[3] = 1'b1;
        free_mode[4] = 1'b1;
        tick(80);
        check(rel_cnt[3] == 3, "R7 source 3 count", rel_cnt[3], 3);
        check(rel_cnt[4] == 3, "R7 source 4 count", rel_cnt[4], 3);
        if (order.size() >= st + 6) begin
            for (int k = 1; k < 6; k++)
                check(order[st+k] != order[st+k-1], "R7 alternation", order[st+k], -1);
        end else begin
            check(1'b0, "R7 packet total", order.size() - st, 6);
        end

        // R9 stall holds the word
        out_ready = 1'b0;
        free_mode[2] = 1'b1;
        tick(4);
        held = out_data;
        check(out_valid, "R9 valid under stall", int'(out_valid), 1);
        check(src_pop == '0, "R9 no pop under stall", int'(src_pop), 0);
        tick(5);
        check(out_valid && out_data == held, "R9 data stable", int'(out_data), int'(held));
        check(rel_cnt[2] == 2, "R9 nothing taken", rel_cnt[2], 2);
        out_ready = 1'b1;
        tick(20);
        check(rel_cnt[2] == 3, "R9 release after stall", rel_cnt[2], 3);

        for (int i = 0; i < NQ; i++)
            check(expq[i].size() == 0, "R8 all words delivered", expq[i].size(), 0);

        finish_run();
    end
endmodule